// File: doc/BRIEF.md
# Serial Register Access Bridge

This block sits on a host processor's memory-mapped bus and gives software access to the 16-bit registers of a remote power-management or peripheral-control chip that is reached over a three-wire serial link. The block decodes a 4 KiB slave window. A host store anywhere inside that window is turned into a remote register write. The write is first placed in a small queue, so the host is not held up while the serial frame goes out.

Remote reads use a command-and-poll scheme. Software writes the wanted register offset to a read-command register, and the transfer then starts without any further trigger. Software then polls a result register. That register holds a busy flag, the returned 16-bit value, and an echo of the register address, so the driver can confirm that the data belongs to its own request. A read never overtakes a queued write: it waits until the write queue is empty before it goes on the wire. A queue status register reports full, empty and a sticky flag for a dropped write.

Top module: `reg_link_bridge`

## Requirements
- R1: After reset the queue status register at 0x30 reads 0x0000_0400 (empty set, full and dropped-write clear), and the result register at 0x2C reads 0.
- R2: A host write to any address from 0x8000 to 0x8FFF queues one remote write of offset address[11:0] with data wdata[15:0]. Queued writes leave in the order they arrived. Host writes to addresses outside that window, other than the registers defined here, queue nothing.
- R3: Each serial frame holds the select line high for 29 bit times: first a direction bit (1 = read, 0 = write), then 12 offset bits, then 16 data bits, all most significant bit first. The data output changes only while the serial clock is low. On a read frame the bridge sends zeros in the data bits and takes in the slave's 16 bits, sampling on each rising serial clock.
- R4: A host write to the read-command register at 0x28 starts a remote read of offset wdata[11:0]. The upper bits of wdata are ignored, and nothing else is needed to start the read.
- R5: Bit 31 of the result register at 0x2C is 1 from the clock edge that accepts a read command until the read has completed. It then returns to 0.
- R6: Once a read has completed, the result register holds the returned value in bits 15:0 and the requested 12-bit offset in bits 27:16, with bits 30:28 at 0.
- R7: The queue holds 8 entries. Bit 11 of 0x30 is 1 while the queue is full, and bit 10 is 1 while it is empty.
- R8: A window write that arrives while the queue is full is dropped and never reaches the slave. It sets bit 12 of 0x30. That bit stays set until the host writes 0x30 with bit 12 at 1.
- R9: An accepted read is not sent until the write queue is empty, so the read returns the value left by every write that was queued before it.
- R10: While bit 31 is set, bits 30:0 of 0x2C keep the previous result. A read command written while bit 31 is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host bus access strobe, one cycle per access |
| host_we | input | 1 | 1 for a host write, 0 for a host read |
| host_addr | input | HOST_AW | Byte address within the block |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| ser_clk | output | 1 | Serial clock toward the slave |
| ser_sel | output | 1 | Frame select, high for the whole frame |
| ser_do | output | 1 | Serial data toward the slave |
| ser_di | input | 1 | Serial data from the slave |

## Verification
The bench puts a read right behind two queued writes to the same offset. If the design let the read overtake the queue, it would return the stale value, and the monitor would see the frames in the wrong order. It also reads the result register in the cycle right after a command, and sends a second command while the first is still in flight. A design that cleared the old fields early, or that took the second command, would show a changed result or an extra read frame. The bench fills the queue to its limit and pushes once more. A design that stored the extra write or lost the sticky flag would reach the slave with that write or report a clear bit 12. Read commands with junk in the upper bits and writes just outside the window check the address decode.

// File: rtl/rlb_pkg.sv
package rlb_pkg;

  localparam int SLV_AW  = 12;
  localparam int REG_DW  = 16;
  localparam int FRAME_W = 1 + SLV_AW + REG_DW;

  localparam logic [15:0] OFS_RDCMD  = 16'h0028;
  localparam logic [15:0] OFS_RDDATA = 16'h002C;
  localparam logic [15:0] OFS_FSTAT  = 16'h0030;
  localparam logic [15:0] WIN_BASE   = 16'h8000;

  localparam int FST_EMPTY = 10;
  localparam int FST_FULL  = 11;
  localparam int FST_OVF   = 12;
  localparam int RDD_BUSY  = 31;

  typedef struct packed {
    logic [SLV_AW-1:0] ofs;
    logic [REG_DW-1:0] dat;
  } wr_item_t;

endpackage

// File: rtl/rlb_wfifo.sv
module rlb_wfifo
  import rlb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  wr_item_t din,
  input  logic     pop,
  output wr_item_t dout,
  output logic     full,
  output logic     empty
);

  // DEPTH must be a power of two: pointers wrap with one extra lap bit
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW:0] wp_q, wp_d, rp_q, rp_d;
  wr_item_t    store_q [DEPTH];
  logic        push_ok, pop_ok;

  assign full    = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
  assign empty   = (wp_q == rp_q);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = store_q[rp_q[PW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (push_ok) wp_d = wp_q + 1'b1;
    if (pop_ok)  rp_d = rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  // storage carries no reset; only written entries are ever read
  always_ff @(posedge clk) begin
    if (push_ok) store_q[wp_q[PW-1:0]] <= din;
  end

  AST_FIFO_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full); // R8

  AST_FIFO_EMPTY_BY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(pop)); // R7

endmodule

// File: rtl/rlb_shifter.sv
module rlb_shifter
  import rlb_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic [SLV_AW-1:0] ofs,
  input  logic [REG_DW-1:0] wdat,
  output logic              busy,
  output logic              done,
  output logic [REG_DW-1:0] rdat,
  output logic              ser_clk,
  output logic              ser_sel,
  output logic              ser_do,
  input  logic              ser_di
);

  localparam int DIVW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BCW  = $clog2(FRAME_W);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(HALF - 1);
  localparam logic [BCW-1:0]  BIT_LAST = BCW'(FRAME_W - 1);

  logic               act_q, act_d;
  logic               sclk_q, sclk_d;
  logic [DIVW-1:0]    div_q, div_d;
  logic [BCW-1:0]     bit_q, bit_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [REG_DW-1:0]  rx_q, rx_d;
  logic               done_q, done_d;
  logic               tick;

  assign tick = act_q && (div_q == DIV_LAST);

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    div_d  = div_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        sclk_d = 1'b0;
        div_d  = '0;
        bit_d  = '0;
        sh_d   = {rd, ofs, (rd ? {REG_DW{1'b0}} : wdat)};
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[REG_DW-2:0], ser_di};
        end else begin
          sclk_d = 1'b0;
          sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
          if (bit_q == BIT_LAST) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign busy    = act_q;
  assign done    = done_q;
  assign rdat    = rx_q;
  assign ser_clk = sclk_q;
  assign ser_sel = act_q;
  assign ser_do  = sh_q[FRAME_W-1];

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_sel |-> !ser_clk); // R3

  AST_DO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ser_clk) && ser_clk) |-> $stable(ser_do)); // R3

endmodule

// File: rtl/reg_link_bridge.sv
module reg_link_bridge
  import rlb_pkg::*;
#(
  parameter int HOST_AW    = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int SCLK_HALF  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               ser_clk,
  output logic               ser_sel,
  output logic               ser_do,
  input  logic               ser_di
);

  localparam logic [HOST_AW-1:0] A_RDCMD  = HOST_AW'(OFS_RDCMD);
  localparam logic [HOST_AW-1:0] A_RDDATA = HOST_AW'(OFS_RDDATA);
  localparam logic [HOST_AW-1:0] A_FSTAT  = HOST_AW'(OFS_FSTAT);
  localparam logic [HOST_AW-1:0] A_WIN    = HOST_AW'(WIN_BASE);
  localparam int ECHO_PAD = 15 - SLV_AW;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  // host decode
  logic host_wr, win_hit, fifo_push, rdcmd_wr, fstat_wr, cmd_acc;

  assign host_wr   = host_req && host_we;
  assign win_hit   = (host_addr[HOST_AW-1:SLV_AW] == A_WIN[HOST_AW-1:SLV_AW]);
  assign fifo_push = host_wr && win_hit;
  assign rdcmd_wr  = host_wr && (host_addr == A_RDCMD);
  assign fstat_wr  = host_wr && (host_addr == A_FSTAT);

  // write queue
  wr_item_t fifo_din, fifo_dout;
  logic     fifo_full, fifo_empty, fifo_pop;

  assign fifo_din = '{ofs: host_addr[SLV_AW-1:0], dat: host_wdata[REG_DW-1:0]};

  rlb_wfifo #(.DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (fifo_push),
    .din   (fifo_din),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  // read sequencer state
  logic              rd_busy_q, rd_busy_d;
  logic              rd_pend_q, rd_pend_d;
  logic              cur_rd_q, cur_rd_d;
  logic [SLV_AW-1:0] rd_ofs_q, rd_ofs_d;
  logic [SLV_AW-1:0] res_ofs_q, res_ofs_d;
  logic [REG_DW-1:0] res_dat_q, res_dat_d;
  logic              ovf_q, ovf_d;

  logic              sh_busy, sh_done, start_wr, start_rd;
  logic [REG_DW-1:0] sh_rdat;
  logic [SLV_AW-1:0] sh_ofs;

  // queued writes go first; a pending read only launches on an empty queue
  assign start_wr = !sh_busy && !fifo_empty;
  assign start_rd = !sh_busy && fifo_empty && rd_pend_q;
  assign fifo_pop = start_wr;
  assign cmd_acc  = rdcmd_wr && !rd_busy_q;
  assign sh_ofs   = start_rd ? rd_ofs_q : fifo_dout.ofs;

  rlb_shifter #(.HALF(SCLK_HALF)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start_wr || start_rd),
    .rd      (start_rd),
    .ofs     (sh_ofs),
    .wdat    (fifo_dout.dat),
    .busy    (sh_busy),
    .done    (sh_done),
    .rdat    (sh_rdat),
    .ser_clk (ser_clk),
    .ser_sel (ser_sel),
    .ser_do  (ser_do),
    .ser_di  (ser_di)
  );

  always_comb begin
    rd_busy_d = rd_busy_q;
    rd_pend_d = rd_pend_q;
    cur_rd_d  = cur_rd_q;
    rd_ofs_d  = rd_ofs_q;
    res_ofs_d = res_ofs_q;
    res_dat_d = res_dat_q;
    ovf_d     = ovf_q;
    if (sh_done && cur_rd_q) begin
      res_dat_d = sh_rdat;
      res_ofs_d = rd_ofs_q;
      rd_busy_d = 1'b0;
    end
    if (cmd_acc) begin
      rd_busy_d = 1'b1;
      rd_pend_d = 1'b1;
      rd_ofs_d  = host_wdata[SLV_AW-1:0];
    end
    if (start_rd) rd_pend_d = 1'b0;
    if (start_wr || start_rd) cur_rd_d = start_rd;
    if (fstat_wr && host_wdata[FST_OVF]) ovf_d = 1'b0;
    if (fifo_push && fifo_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_busy_q <= 1'b0;
      rd_pend_q <= 1'b0;
      cur_rd_q  <= 1'b0;
      rd_ofs_q  <= '0;
      res_ofs_q <= '0;
      res_dat_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      rd_busy_q <= rd_busy_d;
      rd_pend_q <= rd_pend_d;
      cur_rd_q  <= cur_rd_d;
      rd_ofs_q  <= rd_ofs_d;
      res_ofs_q <= res_ofs_d;
      res_dat_q <= res_dat_d;
      ovf_q     <= ovf_d;
    end
  end

  // host read mux
  always_comb begin
    host_rdata = '0;
    if (host_addr == A_RDDATA) begin
      host_rdata = {rd_busy_q, {ECHO_PAD{1'b0}}, res_ofs_q, res_dat_q};
    end else if (host_addr == A_FSTAT) begin
      host_rdata[FST_EMPTY] = fifo_empty;
      host_rdata[FST_FULL]  = fifo_full;
      host_rdata[FST_OVF]   = ovf_q;
    end
  end

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_acc |=> rd_busy_q); // R5

  AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(rd_busy_q) |-> $past(sh_done)); // R5

  AST_ECHO_MATCHES_CMD: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(rd_busy_q) |-> (res_ofs_q == $past(rd_ofs_q))); // R6

  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fifo_push && fifo_full) |=> ovf_q); // R8

  AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(ser_sel) && ser_do) |-> $past(fifo_empty)); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_busy_q && $past(rd_busy_q)) |-> $stable(res_dat_q)); // R10

  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rdcmd_wr && rd_busy_q) |=> $stable(rd_ofs_q)); // R10

endmodule

// File: tb/reg_link_bridge_tb.sv
module reg_link_bridge_tb;
  import rlb_pkg::*;

  localparam int HOST_AW = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               host_req, host_we;
  logic [HOST_AW-1:0] host_addr;
  logic [31:0]        host_wdata, host_rdata;
  logic               ser_clk, ser_sel, ser_do;
  logic               ser_di = 1'b0;

  always #5 clk = ~clk;

  reg_link_bridge #(.HOST_AW(HOST_AW), .FIFO_DEPTH(8), .SCLK_HALF(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ser_clk    (ser_clk),
    .ser_sel    (ser_sel),
    .ser_do     (ser_do),
    .ser_di     (ser_di)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // initial contents of a slave register, computed
  function automatic logic [15:0] init_val(input logic [11:0] a);
    return 16'({a, 4'h3}) ^ 16'h5A3C;
  endfunction

  logic [15:0] smem [int];    // slave model registers
  logic [15:0] shadow [int];  // expected contents

  function automatic logic [15:0] smem_rd(input logic [11:0] a);
    return smem.exists(int'(a)) ? smem[int'(a)] : init_val(a);
  endfunction

  function automatic logic [15:0] shadow_rd(input logic [11:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
  endfunction

  // scoreboard of expected frames
  typedef struct {
    bit          rd;
    logic [11:0] a;
    logic [15:0] d;
  } frm_t;
  frm_t exq[$];
  int   n_frames = 0;

  // behavioural slave and frame monitor
  int          scnt = 0;
  logic [28:0] ssh = '0;
  logic [15:0] sword = '0;
  bit          s_rd = 0;

  always @(posedge ser_sel) begin
    scnt = 0;
    s_rd = 0;
  end

  always @(posedge ser_clk) begin
    if (ser_sel) begin
      ssh = {ssh[27:0], ser_do};
      if (scnt == 12) begin
        s_rd  = ssh[12];
        sword = smem_rd(ssh[11:0]);
      end
      if (scnt == 28) begin
        frm_t got;
        got.rd = ssh[28];
        got.a  = ssh[27:16];
        got.d  = ssh[15:0];
        n_frames++;
        if (!got.rd) smem[int'(got.a)] = got.d;
        if (exq.size() == 0) begin
          check(0, "R2 unexpected frame", {3'b0, got.rd, got.a, got.d}, 32'h0);
        end else begin
          frm_t ex;
          ex = exq.pop_front();
          // R3 frame fields and R9 order: reads carry zero data bits
          check(got.rd == ex.rd && got.a == ex.a && got.d == (ex.rd ? 16'h0 : ex.d),
                "R3 frame content/order", {3'b0, got.rd, got.a, got.d},
                {3'b0, ex.rd, ex.a, (ex.rd ? 16'h0 : ex.d)});
        end
      end
      scnt++;
    end
  end

  always @(negedge ser_clk) begin
    if (ser_sel && s_rd && scnt >= 13 && scnt <= 28) ser_di = sword[28 - scnt];
  end

  // driver tasks
  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic win_wr(input logic [11:0] ofs, input logic [15:0] d, input bit accept);
    if (accept) begin
      frm_t f;
      f.rd = 0; f.a = ofs; f.d = d;
      exq.push_back(f);
      shadow[int'(ofs)] = d;
    end
    bus_wr(WIN_BASE + 16'(ofs), {16'hDEAD, d});
  endtask

  task automatic rd_cmd(input logic [31:0] cmdword);
    frm_t f;
    f.rd = 1; f.a = cmdword[11:0]; f.d = '0;
    exq.push_back(f);
    bus_wr(OFS_RDCMD, cmdword);
  endtask

  task automatic wait_result(input logic [11:0] ofs, input string req);
    logic [31:0] v;
    int guard = 0;
    do begin
      rd_reg(OFS_RDDATA, v);
      guard++;
    end while (v[31] && guard < 5000);
    check(v == {1'b0, 3'b000, ofs, shadow_rd(ofs)}, req, v, {1'b0, 3'b000, ofs, shadow_rd(ofs)});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int guard = 0;
    do begin
      rd_reg(OFS_FSTAT, v);
      guard++;
    end while (!(v[FST_EMPTY] && !ser_sel) && guard < 5000);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int frames_before;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(OFS_FSTAT, v);
    check(v == 32'h0000_0400, "R1 status after reset", v, 32'h0000_0400);
    rd_reg(OFS_RDDATA, v);
    check(v == 32'h0, "R1 result after reset", v, 32'h0);

    // R2 window writes forwarded in order
    win_wr(12'h010, 16'h1234, 1);
    win_wr(12'hFFE, 16'hBEEF, 1);
    win_wr(12'h7A2, 16'h0F0F, 1);
    wait_idle();
    check(smem_rd(12'h010) == 16'h1234, "R2 slave got first write", 32'(smem_rd(12'h010)), 32'h1234);
    check(smem_rd(12'hFFE) == 16'hBEEF, "R2 slave got top-of-window write", 32'(smem_rd(12'hFFE)), 32'hBEEF);

    // R2 writes outside the window queue nothing
    frames_before = n_frames;
    bus_wr(16'h7FFE, 32'h5);
    bus_wr(16'h9000, 32'h6);
    bus_wr(16'h0040, 32'h7);
    rd_reg(OFS_FSTAT, v);
    check(v[FST_EMPTY] == 1'b1, "R2 outside-window write not queued", v, 32'h400);
    repeat (200) @(negedge clk);
    check(n_frames == frames_before, "R2 no frame for outside-window write", 32'(n_frames), 32'(frames_before));

    // R4 R5 R6 R10 basic read, busy seen right after the command
    rd_cmd(32'h0000_0010);
    rd_reg(OFS_RDDATA, v);
    check(v == 32'h8000_0000, "R5 busy with old fields kept (R10)", v, 32'h8000_0000);
    wait_result(12'h010, "R6 read result and echo");

    // R10 second command while busy is ignored
    rd_cmd(32'h0000_07A2);
    exq.pop_back(); // pushed by rd_cmd, expected to stay, re-added below
    begin frm_t f; f.rd = 1; f.a = 12'h7A2; f.d = '0; exq.push_back(f); end
    rd_reg(OFS_RDDATA, v);
    check(v == {1'b1, 3'b000, 12'h010, 16'h1234}, "R10 busy keeps previous result", v,
          {1'b1, 3'b000, 12'h010, 16'h1234});
    bus_wr(OFS_RDCMD, 32'h0000_0003);
    wait_result(12'h7A2, "R10 command during busy ignored");

    // R4 upper command bits ignored, R6 echo padding zero
    rd_cmd(32'hFFFF_FFFE);
    wait_result(12'hFFE, "R4 upper command bits ignored");

    // R9 read queued behind writes to the same register
    win_wr(12'h123, 16'hCAFE, 1);
    win_wr(12'h123, 16'hD00D, 1);
    rd_cmd(32'h0000_0123);
    wait_result(12'h123, "R9 read sees queued writes");
    wait_idle();

    // R7 R8 fill the queue, then overflow
    for (int i = 0; i < 9; i++) win_wr(12'h200 + 12'(i), 16'hA000 + 16'(i), 1);
    rd_reg(OFS_FSTAT, v);
    check(v == 32'h0000_0800, "R7 queue full flag", v, 32'h0000_0800);
    win_wr(12'h209, 16'h7777, 0);
    rd_reg(OFS_FSTAT, v);
    check(v == 32'h0000_1800, "R8 overflow sticky set", v, 32'h0000_1800);
    wait_idle();
    check(smem_rd(12'h209) == init_val(12'h209), "R8 dropped write not forwarded",
          32'(smem_rd(12'h209)), 32'(init_val(12'h209)));
    rd_reg(OFS_FSTAT, v);
    check(v == 32'h0000_1400, "R8 overflow stays after drain (R7 empty)", v, 32'h0000_1400);
    bus_wr(OFS_FSTAT, 32'h0000_1000);
    rd_reg(OFS_FSTAT, v);
    check(v == 32'h0000_0400, "R8 overflow cleared by write", v, 32'h0000_0400);
    check(smem_rd(12'h208) == 16'hA008, "R7 last queued entry forwarded", 32'(smem_rd(12'h208)), 32'hA008);

    repeat (20) @(negedge clk);
    check(exq.size() == 0, "R3 all expected frames seen", 32'(exq.size()), 32'h0);
    finish_run();
  end

endmodule